// File: doc/BRIEF.md
# DMA Channel Event Flag and Interrupt Register Block

This block records the per-channel event flags of a seven-channel DMA controller. Each channel engine sends single-cycle pulses for transfer error, half transfer and transfer complete. The block latches each pulse into a sticky flag. It also keeps a derived summary flag per channel, which is high while any of that channel's three event flags is set.

Software sees the flags through a small register bus with two words. A read-only status word packs all channels into four-bit groups. A write-one-to-clear word uses the same bit positions to acknowledge events. Reading a cause and then clearing it consumes the event, so each cause can be serviced only once.

Each channel drives one interrupt line. The line is gated per cause by enable bits that come from the channel configuration. A helper port returns the four flags of one selected channel, right-aligned, for fast dispatch in an interrupt handler.

Top module: `dma_irq_flags`

## Requirements
- R1: After reset every flag is zero, every `irq_o` bit is low, `pick_flags_o` is zero, and the status word reads zero.
- R2: An event pulse sampled at a rising clock edge sets its flag from that edge on. Channel n (1..7) uses status bits [4(n-1)+3 : 4(n-1)]: bit 0 is summary, bit 1 is complete, bit 2 is half, bit 3 is error. Status bits 31..28 read zero.
- R3: A channel's summary bit is the OR of its error, half and complete flags.
- R4: An event flag stays set with no further pulse until a clear removes it.
- R5: A bus write to address 1 clears, at the edge, each complete, half or error flag whose position in the written data is one. Zero bits leave their flags unchanged.
- R6: A one written to a channel's summary position at address 1 clears all of that channel's flags.
- R7: When an event pulse and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: Writes to address 0 or to addresses 2..3 change no flag. Reads of address 1, 2 or 3 return zero, and only address 0 returns the status word.
- R9: `irq_o[n-1]` is high exactly when (error and `err_ie_i`) or (half and `half_ie_i`) or (complete and `done_ie_i`) holds for channel n. Enables act combinationally on the line.
- R10: For `pick_ch_i` in 1..7, `pick_flags_o` gives {error, half, complete, summary} of that channel, with error at bit 3. For 0 it gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 2 | Word address: 0 status, 1 clear |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data (combinational) |
| err_evt_i | input | 7 | Per-channel transfer error pulse |
| half_evt_i | input | 7 | Per-channel half-transfer pulse |
| done_evt_i | input | 7 | Per-channel transfer-complete pulse |
| err_ie_i | input | 7 | Per-channel error interrupt enable |
| half_ie_i | input | 7 | Per-channel half interrupt enable |
| done_ie_i | input | 7 | Per-channel complete interrupt enable |
| irq_o | output | 7 | Per-channel interrupt line |
| pick_ch_i | input | 3 | Channel number for the helper read-back |
| pick_flags_o | output | 4 | Selected channel flags, right-aligned |

## Verification
A flag that is lost, stuck or wrongly cleared shows up in the status word, the helper port and the interrupt line in the cycle after the event or clear edge. All three are compared against a behavioural model on every clock. The model is driven through directed set/clear collisions, summary clears, ignored writes and a long stretch of mixed random traffic, so a bad bit position or a wrong set/clear priority gives a mismatch within one cycle of its first use.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int GRP_W    = 4;
  localparam int SUM_BIT  = 0;
  localparam int DONE_BIT = 1;
  localparam int HALF_BIT = 2;
  localparam int ERR_BIT  = 3;
  localparam logic [1:0] STAT_ADDR = 2'd0;
  localparam logic [1:0] CLR_ADDR  = 2'd1;

  // event vector order inside a channel cell
  typedef struct packed {
    logic err;
    logic half;
    logic done;
  } evt_t;
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  evt_t       evt_i,
  input  logic [GRP_W-1:0] clr_i,
  input  evt_t       ie_i,
  output logic [GRP_W-1:0] flags_o,
  output logic       irq_o
);
  evt_t f_q, f_d, clr_m;

  always_comb begin
    clr_m.err  = clr_i[SUM_BIT] | clr_i[ERR_BIT];
    clr_m.half = clr_i[SUM_BIT] | clr_i[HALF_BIT];
    clr_m.done = clr_i[SUM_BIT] | clr_i[DONE_BIT];
    // set beats clear
    f_d = (f_q & ~clr_m) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) f_q <= '0;
    else         f_q <= f_d;
  end

  always_comb begin
    flags_o           = '0;
    flags_o[ERR_BIT]  = f_q.err;
    flags_o[HALF_BIT] = f_q.half;
    flags_o[DONE_BIT] = f_q.done;
    flags_o[SUM_BIT]  = |f_q;
  end

  assign irq_o = |(f_q & ie_i);

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((f_q & $past(evt_i)) == $past(evt_i)));
  // R6
  sum_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[SUM_BIT] && evt_i == '0) |=> (flags_o == '0));
  // R4
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0 && clr_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/dma_irq_pick.sv
module dma_irq_pick
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int SEL_W  = 3
) (
  input  logic [GRP_W*NUM_CH-1:0] word_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [GRP_W-1:0]        flags_o
);
  always_comb begin
    flags_o = '0;
    for (int k = 0; k < NUM_CH; k++)
      if (sel_i == SEL_W'(k + 1)) flags_o = word_i[GRP_W*k +: GRP_W];
  end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int ADDR_W = 2,
  parameter int SEL_W  = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic [NUM_CH-1:0] half_evt_i,
  input  logic [NUM_CH-1:0] done_evt_i,
  input  logic [NUM_CH-1:0] err_ie_i,
  input  logic [NUM_CH-1:0] half_ie_i,
  input  logic [NUM_CH-1:0] done_ie_i,
  output logic [NUM_CH-1:0] irq_o,
  input  logic [SEL_W-1:0]  pick_ch_i,
  output logic [GRP_W-1:0]  pick_flags_o
);
  localparam int STAT_W = GRP_W * NUM_CH;

  logic [STAT_W-1:0] status_w;
  logic [DATA_W-1:0] clr_w;

  // R5 R8
  assign clr_w = (bus_wr_i && bus_addr_i == ADDR_W'(CLR_ADDR)) ? bus_wdata_i : '0;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    evt_t evt, ie;
    assign evt = '{err: err_evt_i[k], half: half_evt_i[k], done: done_evt_i[k]};
    assign ie  = '{err: err_ie_i[k],  half: half_ie_i[k],  done: done_ie_i[k]};
    dma_irq_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt),
      .clr_i   (clr_w[GRP_W*k +: GRP_W]),
      .ie_i    (ie),
      .flags_o (status_w[GRP_W*k +: GRP_W]),
      .irq_o   (irq_o[k])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(STAT_ADDR)) bus_rdata_o[STAT_W-1:0] = status_w;
  end

  dma_irq_pick #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_pick (
    .word_i  (status_w),
    .sel_i   (pick_ch_i),
    .flags_o (pick_flags_o)
  );

  // R10
  pick_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(STAT_ADDR) && pick_ch_i == SEL_W'(1))
      |-> (pick_flags_o == bus_rdata_o[GRP_W-1:0]));
  // R9
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(STAT_ADDR) && irq_o[0]) |-> bus_rdata_o[SUM_BIT]);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (irq_o == '0));
endmodule

// File: tb/tb_dma_irq_flags.sv
module tb_dma_irq_flags;
  localparam int N = 7;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [N-1:0] ev_e = 0, ev_h = 0, ev_d = 0, ie_e = 0, ie_h = 0, ie_d = 0, irq;
  logic [2:0]  pick = 0;
  logic [3:0]  pflags;

  int checks = 0, errors = 0;
  bit done_run = 0;
  bit m_e[N], m_h[N], m_d[N];

  always #5 clk = ~clk;

  dma_irq_flags dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .err_evt_i(ev_e),
    .half_evt_i(ev_h), .done_evt_i(ev_d), .err_ie_i(ie_e), .half_ie_i(ie_h),
    .done_ie_i(ie_d), .irq_o(irq), .pick_ch_i(pick), .pick_flags_o(pflags)
  );

  function automatic logic [3:0] grp(int c);
    logic s = m_e[c] | m_h[c] | m_d[c];
    return {m_e[c], m_h[c], m_d[c], s};
  endfunction

  function automatic logic [31:0] status_exp();
    logic [31:0] w = 0;
    for (int c = 0; c < N; c++) w[4*c +: 4] = grp(c);
    return w;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic [31:0] er = (addr == 2'd0) ? status_exp() : 32'h0;
    logic [N-1:0] ei;
    logic [3:0] ep = (pick >= 1 && pick <= N) ? grp(int'(pick) - 1) : 4'h0;
    for (int c = 0; c < N; c++)
      ei[c] = (m_e[c] & ie_e[c]) | (m_h[c] & ie_h[c]) | (m_d[c] & ie_d[c]);
    chk(tag, "rdata", rdata, er);
    chk(tag, "irq", 32'(irq), 32'(ei));
    chk(tag, "pick", 32'(pflags), 32'(ep));
  endtask

  // one clock: model update at edge from held inputs, compare at negedge
  task automatic step(string tag);
    @(posedge clk);
    for (int c = 0; c < N; c++) begin
      logic [3:0] cl = (wr && addr == 2'd1) ? wdata[4*c +: 4] : 4'h0;
      if (cl[0] || cl[3]) m_e[c] = 0;
      if (cl[0] || cl[2]) m_h[c] = 0;
      if (cl[0] || cl[1]) m_d[c] = 0;
      if (ev_e[c]) m_e[c] = 1;
      if (ev_h[c]) m_h[c] = 1;
      if (ev_d[c]) m_d[c] = 1;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    wr = 0; wdata = 0; ev_e = 0; ev_h = 0; ev_d = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done_run) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N; c++) begin m_e[c] = 0; m_h[c] = 0; m_d[c] = 0; end
    ie_e = '1; ie_h = '1; ie_d = '1;
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1;
    step("R1");

    // R2 R3: each cause per channel, walk pick
    for (int c = 0; c < N; c++) begin
      pick = 3'(c + 1);
      idle(); ev_d[c] = 1; step("R2");
      idle(); ev_h[c] = 1; step("R3");
      idle(); ev_e[c] = 1; step("R10");
    end
    idle();
    chk("R2", "full status", rdata, 32'h0FFF_FFFF);
    repeat (3) step("R4");

    // R8: write to status and spare addresses, read spares
    for (int a = 0; a < 4; a++) begin
      if (a == 1) continue;
      addr = 2'(a); wr = 1; wdata = '1; step("R8");
      idle(); step("R8");
    end
    addr = 0; step("R8");

    // R5: clear single causes; zeros do nothing
    addr = 1; wr = 1; wdata = 32'h0; step("R5");
    wdata = 32'h0000_0002; step("R5");
    wdata = 32'h0000_0040; step("R5");
    wdata = 32'h0000_8000; step("R5");
    idle(); addr = 0; pick = 1; step("R5");

    // R6: summary clear of channel 3
    addr = 1; wr = 1; wdata = 32'h0000_0100; step("R6");
    idle(); addr = 0; pick = 3; step("R6");
    chk("R6", "ch3 group", 32'(rdata[11:8]), 32'h0);

    // R7: set and clear together
    addr = 1; wr = 1; wdata = 32'h0000_0100; ev_h[2] = 1; step("R7");
    idle(); addr = 0; step("R7");
    chk("R7", "ch3 half kept", 32'(rdata[11:8]), 32'h5);

    // R9: enables gate lines combinationally
    ie_e = 0; ie_h = 0; ie_d = 0; step("R9");
    ie_h[2] = 1; step("R9");
    ie_h = 0; ie_d = '1; step("R9");
    pick = 0; step("R10");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      ev_e = N'($urandom) & N'($urandom);
      ev_h = N'($urandom) & N'($urandom);
      ev_d = N'($urandom) & N'($urandom);
      ie_e = N'($urandom); ie_h = N'($urandom); ie_d = N'($urandom);
      wr = $urandom_range(0, 2) == 0;
      addr = 2'($urandom);
      wdata = $urandom & $urandom;
      pick = 3'($urandom);
      step("R7");
    end
    idle(); addr = 1; wr = 1; wdata = '1; step("R6");
    idle(); addr = 0; step("R6");

    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule